// File: doc/BRIEF.md
# Power-Domain Reset Release Sequencer

This block orders the reset lines of one switchable power domain as the domain comes back from retention or off. It drives four active-high reset outputs into the domain: a cold reset, and warm resets for the processor core, the memory-management unit and the sequencer coprocessor. It also drives a clock-enable for the domain. When the domain power input drops, every reset is raised at once without waiting for a clock edge. When power returns, the resets come down in stages. Each stage waits on a programmable countdown, on a handshake from the domain, or on a hold bit that software owns.

Software acts through plain write strobes. One strobe writes the three hold bits, one per warm-style hold. Two strobes load the 8-bit countdown values. One strobe clears status flags, with a 1 in a data bit clearing that flag. The hold bits and the two status flags are visible on output pins. The status flags record that the cold reset and the sequencer reset were released.

Top module: `pd_reset_seq`

## Requirements
- R1: After `rst_n` is released with `dom_on` low, all four reset outputs read 1, `dom_clk_en` reads 0, `hold_q` reads 3'b100 and `sts_q` reads 2'b00.
- R2: While `dom_on` is low, all four reset outputs are 1 in the same cycle, with no clock edge needed. `dom_clk_en` falls at the first clock edge that samples `dom_on` low. On the next wake, every reset starts again from the asserted state.
- R3: At the clock edge that first samples `dom_on` high after it was low, `hold_q[2]` (sequencer hold) becomes 1, whatever software wrote before. `dom_clk_en` becomes 1 at that same edge.
- R4: With `hold_q[1]` at 0 and cold count N, `cold_rst` falls at clock edge N+2. The first edge that samples `dom_on` high counts as edge 1.
- R5: While `hold_q[1]` (MMU hold) is 1, `cold_rst` stays asserted even after its countdown has expired. It falls at the second edge counted from the edge that writes the bit to 0. Setting the bit after release does not reassert `cold_rst`.
- R6: `mmu_rst` and `core_rst` stay asserted until `init_done` is sampled high while `cold_rst` is released. They fall at that edge. A later drop of `init_done` leaves them released.
- R7: While `hold_q[0]` (core hold) is 1, `core_rst` stays asserted after the done handshake even if `init_done` later falls, and `mmu_rst` releases regardless. `core_rst` falls at the second edge counted from the edge that writes the bit to 0.
- R8: With `mmu_rst` already released and sequencer count M, `seq_rst` falls at edge M+2. The edge that writes `hold_q[2]` to 0 counts as edge 1.
- R9: `seq_rst` stays asserted while `mmu_rst` is asserted, even with `hold_q[2]` at 0. Its countdown starts only once `mmu_rst` falls, and it falls M+1 edges after the edge at which `mmu_rst` fell.
- R10: `sts_q[0]` becomes 1 at the edge where `cold_rst` is released, and `sts_q[1]` becomes 1 at the edge where `seq_rst` is released.
- R11: A `sts_clr_we` strobe clears each `sts_q` bit whose `sts_clr_data` bit is 1 and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_on | input | 1 | Domain power state, 1 = on |
| init_done | input | 1 | Initialization-complete signal from the domain |
| hold_we | input | 1 | Write strobe for the hold bits |
| hold_wdata | input | 3 | Hold bits: [0] core, [1] MMU, [2] sequencer |
| cold_cnt_we | input | 1 | Write strobe for the cold countdown value |
| seq_cnt_we | input | 1 | Write strobe for the sequencer countdown value |
| cnt_wdata | input | 8 | Countdown value to write |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_data | input | 2 | Bits to clear: [0] cold released, [1] sequencer released |
| cold_rst | output | 1 | Cold reset into the domain, active high |
| core_rst | output | 1 | Core warm reset, active high |
| mmu_rst | output | 1 | MMU warm reset, active high |
| seq_rst | output | 1 | Sequencer warm reset, active high |
| dom_clk_en | output | 1 | Domain clock enable |
| hold_q | output | 3 | Current hold bits |
| sts_q | output | 2 | Sticky release flags |

## Verification
The hardest state to reach is a sequencer hold that software has already cleared while the MMU reset is still asserted. The wake itself sets the hold bit, so software can only clear it after the wake. To get there, the stimulus wakes the domain with a long cold countdown and writes the hold bits to zero while the cold reset is still counting down. It then keeps `init_done` low well past the cold release, and only raises it later. The sequencer latency is then counted from the edge at which `mmu_rst` falls. This separates a countdown that honours the stall from one that ran ahead while the MMU reset was still held.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int HOLD_CORE = 0;
  localparam int HOLD_MMU  = 1;
  localparam int HOLD_SEQ  = 2;
  localparam int NUM_HOLD  = 3;

  localparam int STS_COLD  = 0;
  localparam int STS_SEQ   = 1;
  localparam int NUM_STS   = 2;

  localparam int TMR_COLD  = 0;
  localparam int TMR_SEQ   = 1;
  localparam int NUM_TMR   = 2;

  typedef struct packed {
    logic seq;
    logic mmu;
    logic core;
    logic cold;
  } rst_bus_t;
endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  // Reload every cycle the wait is inactive, so each new wait starts full.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/rsq_regs.sv
module rsq_regs
  import rsq_pkg::*;
#(
  parameter int                CW        = 8,
  parameter logic [CW-1:0]     COLD_INIT = 8'd4,
  parameter logic [CW-1:0]     SEQ_INIT  = 8'd4,
  parameter logic [NUM_HOLD-1:0] HOLD_INIT = 3'b100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake,
  input  logic                hold_we,
  input  logic [NUM_HOLD-1:0] hold_wdata,
  input  logic                cold_cnt_we,
  input  logic                seq_cnt_we,
  input  logic [CW-1:0]       cnt_wdata,
  input  logic                sts_clr_we,
  input  logic [NUM_STS-1:0]  sts_clr_data,
  input  logic [NUM_STS-1:0]  sts_set,
  output logic [NUM_HOLD-1:0] hold_q,
  output logic [CW-1:0]       cold_cnt,
  output logic [CW-1:0]       seq_cnt,
  output logic [NUM_STS-1:0]  sts_q
);
  logic [NUM_HOLD-1:0] hold_d;

  always_comb begin
    hold_d = hold_we ? hold_wdata : hold_q;
    if (wake) hold_d[HOLD_SEQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= HOLD_INIT;
      cold_cnt <= COLD_INIT;
      seq_cnt  <= SEQ_INIT;
    end else begin
      hold_q <= hold_d;
      if (cold_cnt_we) cold_cnt <= cnt_wdata;
      if (seq_cnt_we)  seq_cnt  <= cnt_wdata;
    end
  end

  // A set and a clear in the same cycle: the set wins.
  for (genvar i = 0; i < NUM_STS; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts_q[i] <= 1'b0;
      end else if (sts_set[i]) begin
        sts_q[i] <= 1'b1;
      end else if (sts_clr_we && sts_clr_data[i]) begin
        sts_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsq_release.sv
module rsq_release
  import rsq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dom_on,
  input  logic                init_done,
  input  logic [NUM_HOLD-1:0] hold,
  input  logic                cold_exp,
  input  logic                seq_exp,
  output rst_bus_t            st,
  output logic                cold_rel,
  output logic                seq_rel
);
  logic done_seen;
  logic done_ok;
  logic mmu_rel;
  logic core_rel;

  // Done is latched so the warm resets survive the domain dropping it.
  assign done_ok  = done_seen || (!st.cold && init_done);
  assign cold_rel = dom_on && st.cold && cold_exp && !hold[HOLD_MMU];
  assign mmu_rel  = dom_on && st.mmu && done_ok;
  assign core_rel = dom_on && st.core && done_ok && !hold[HOLD_CORE];
  assign seq_rel  = dom_on && st.seq && seq_exp;

  always_ff @(posedge clk) begin
    if (!rst_n || !dom_on) begin
      st        <= '{seq: 1'b1, mmu: 1'b1, core: 1'b1, cold: 1'b1};
      done_seen <= 1'b0;
    end else begin
      if (cold_rel) st.cold <= 1'b0;
      if (mmu_rel)  st.mmu  <= 1'b0;
      if (core_rel) st.core <= 1'b0;
      if (seq_rel)  st.seq  <= 1'b0;
      if (!st.cold && init_done) done_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/pd_reset_seq.sv
module pd_reset_seq
  import rsq_pkg::*;
#(
  parameter int                  CNT_W         = 8,
  parameter logic [CNT_W-1:0]    COLD_CNT_RST  = 8'd4,
  parameter logic [CNT_W-1:0]    SEQ_CNT_RST   = 8'd4,
  parameter logic [NUM_HOLD-1:0] HOLD_RST      = 3'b100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dom_on,
  input  logic                init_done,
  input  logic                hold_we,
  input  logic [NUM_HOLD-1:0] hold_wdata,
  input  logic                cold_cnt_we,
  input  logic                seq_cnt_we,
  input  logic [CNT_W-1:0]    cnt_wdata,
  input  logic                sts_clr_we,
  input  logic [NUM_STS-1:0]  sts_clr_data,
  output logic                cold_rst,
  output logic                core_rst,
  output logic                mmu_rst,
  output logic                seq_rst,
  output logic                dom_clk_en,
  output logic [NUM_HOLD-1:0] hold_q,
  output logic [NUM_STS-1:0]  sts_q
);
  logic                dom_q;
  logic                wake;
  rst_bus_t            st;
  logic                cold_rel;
  logic                seq_rel;
  logic [CNT_W-1:0]    cold_cnt;
  logic [CNT_W-1:0]    seq_cnt;
  logic [NUM_STS-1:0]  sts_set;
  logic [NUM_TMR-1:0]  tmr_run;
  logic [NUM_TMR-1:0]  tmr_exp;
  logic [CNT_W-1:0]    tmr_load [NUM_TMR];

  always_ff @(posedge clk) begin
    if (!rst_n) dom_q <= 1'b0;
    else        dom_q <= dom_on;
  end

  assign wake       = dom_on && !dom_q;
  assign dom_clk_en = dom_q;

  assign sts_set[STS_COLD] = cold_rel;
  assign sts_set[STS_SEQ]  = seq_rel;

  rsq_regs #(
    .CW        (CNT_W),
    .COLD_INIT (COLD_CNT_RST),
    .SEQ_INIT  (SEQ_CNT_RST),
    .HOLD_INIT (HOLD_RST)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake         (wake),
    .hold_we      (hold_we),
    .hold_wdata   (hold_wdata),
    .cold_cnt_we  (cold_cnt_we),
    .seq_cnt_we   (seq_cnt_we),
    .cnt_wdata    (cnt_wdata),
    .sts_clr_we   (sts_clr_we),
    .sts_clr_data (sts_clr_data),
    .sts_set      (sts_set),
    .hold_q       (hold_q),
    .cold_cnt     (cold_cnt),
    .seq_cnt      (seq_cnt),
    .sts_q        (sts_q)
  );

  // Wait conditions: cold waits on the clock being back, the sequencer
  // waits on its hold bit being clear and on the MMU reset having gone.
  assign tmr_run[TMR_COLD]  = dom_q && st.cold;
  assign tmr_run[TMR_SEQ]   = dom_q && st.seq && !st.mmu && !hold_q[HOLD_SEQ];
  assign tmr_load[TMR_COLD] = cold_cnt;
  assign tmr_load[TMR_SEQ]  = seq_cnt;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    rsq_timer #(.W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (tmr_run[g]),
      .load_val (tmr_load[g]),
      .expired  (tmr_exp[g])
    );
  end

  rsq_release u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .dom_on    (dom_on),
    .init_done (init_done),
    .hold      (hold_q),
    .cold_exp  (tmr_exp[TMR_COLD]),
    .seq_exp   (tmr_exp[TMR_SEQ]),
    .st        (st),
    .cold_rel  (cold_rel),
    .seq_rel   (seq_rel)
  );

  // Loss of power asserts every reset without waiting for a clock edge.
  assign cold_rst = st.cold || !dom_on;
  assign core_rst = st.core || !dom_on;
  assign mmu_rst  = st.mmu  || !dom_on;
  assign seq_rst  = st.seq  || !dom_on;
endmodule

// File: rtl/rsq_checks.sv
module rsq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       dom_on,
  input logic       cold_rst,
  input logic       core_rst,
  input logic       mmu_rst,
  input logic       seq_rst,
  input logic [2:0] hold_q,
  input logic [1:0] sts_q
);
  AST_OFF_ALL_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_on |-> (cold_rst && core_rst && mmu_rst && seq_rst)); // R2

  AST_WAKE_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_on && !$past(dom_on)) |=> hold_q[2]); // R3

  AST_MMU_HOLD_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_rst && hold_q[1]) |=> cold_rst); // R5

  AST_WARM_AFTER_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mmu_rst || !core_rst) |-> !cold_rst); // R6

  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && hold_q[0]) |=> core_rst); // R7

  AST_SEQ_AFTER_MMU: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_rst |-> !mmu_rst); // R9

  AST_COLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cold_rst) |-> sts_q[0]); // R10

  AST_SEQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_rst) |-> sts_q[1]); // R10
endmodule

bind pd_reset_seq rsq_checks u_rsq_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .dom_on   (dom_on),
  .cold_rst (cold_rst),
  .core_rst (core_rst),
  .mmu_rst  (mmu_rst),
  .seq_rst  (seq_rst),
  .hold_q   (hold_q),
  .sts_q    (sts_q)
);

// File: tb/pd_reset_seq_test.sv
module pd_reset_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dom_on = 1'b0;
  logic       init_done = 1'b0;
  logic       hold_we = 1'b0;
  logic [2:0] hold_wdata = 3'b000;
  logic       cold_cnt_we = 1'b0;
  logic       seq_cnt_we = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic       sts_clr_we = 1'b0;
  logic [1:0] sts_clr_data = 2'b00;
  logic       cold_rst, core_rst, mmu_rst, seq_rst, dom_clk_en;
  logic [2:0] hold_q;
  logic [1:0] sts_q;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pd_reset_seq uut (
    .clk(clk), .rst_n(rst_n), .dom_on(dom_on), .init_done(init_done),
    .hold_we(hold_we), .hold_wdata(hold_wdata),
    .cold_cnt_we(cold_cnt_we), .seq_cnt_we(seq_cnt_we), .cnt_wdata(cnt_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .cold_rst(cold_rst), .core_rst(core_rst), .mmu_rst(mmu_rst),
    .seq_rst(seq_rst), .dom_clk_en(dom_clk_en), .hold_q(hold_q), .sts_q(sts_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rst_of(input int sel);
    case (sel)
      0: return cold_rst;
      1: return core_rst;
      2: return mmu_rst;
      default: return seq_rst;
    endcase
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_low(input int sel, output int n);
    n = 0;
    while (rst_of(sel) && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wr_hold(input logic [2:0] v);
    hold_we = 1'b1; hold_wdata = v;
    @(negedge clk);
    hold_we = 1'b0;
  endtask

  // Write the hold bits and count edges (write edge = 1) until sel falls.
  task automatic wr_hold_measure(input logic [2:0] v, input int sel, output int n);
    hold_we = 1'b1; hold_wdata = v;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      hold_we = 1'b0;
    end while (rst_of(sel) && n < 400);
  endtask

  task automatic wr_cnt(input bit seq, input logic [7:0] v);
    cold_cnt_we = !seq; seq_cnt_we = seq; cnt_wdata = v;
    @(negedge clk);
    cold_cnt_we = 1'b0; seq_cnt_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [1:0] v);
    sts_clr_we = 1'b1; sts_clr_data = v;
    @(negedge clk);
    sts_clr_we = 1'b0;
  endtask

  task automatic power_down();
    dom_on = 1'b0; init_done = 1'b0;
    cycles(2);
  endtask

  task automatic t_reset();
    chk("R1 cold", cold_rst, 1); chk("R1 core", core_rst, 1);
    chk("R1 mmu", mmu_rst, 1);   chk("R1 seq", seq_rst, 1);
    chk("R1 clk_en", dom_clk_en, 0);
    chk("R1 hold", hold_q, 3'b100);
    chk("R1 sts", sts_q, 0);
  endtask

  task automatic t_cold_latency(input int n_cnt);
    int n;
    power_down();
    wr_cnt(1'b0, n_cnt[7:0]);
    wr_hold(3'b000);
    dom_on = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R3 clk_en on wake", dom_clk_en, 1);
    chk("R3 seq hold set on wake", hold_q[2], 1);
    n = 1;
    if (cold_rst) begin
      wait_low(0, n);
      n = n + 1;
    end
    chk("R4 cold latency", n, n_cnt + 2);
    chk("R10 cold flag", sts_q[0], 1);
  endtask

  task automatic t_mmu_hold_and_done();
    int n;
    power_down();
    wr_cnt(1'b0, 8'd2);
    wr_hold(3'b010);
    dom_on = 1'b1;
    cycles(12);
    chk("R5 cold held by mmu hold", cold_rst, 1);
    wr_hold_measure(3'b000, 0, n);
    chk("R5 cold after hold clear", n, 2);
    wr_hold(3'b010);
    cycles(3);
    chk("R5 setting hold does not reassert", cold_rst, 0);
    wr_hold(3'b000);
    cycles(4);
    chk("R6 mmu waits done", mmu_rst, 1);
    chk("R6 core waits done", core_rst, 1);
    init_done = 1'b1;
    wait_low(2, n);
    chk("R6 mmu on done", n, 1);
    chk("R6 core on done", core_rst, 0);
    init_done = 1'b0;
    cycles(3);
    chk("R6 mmu stays after done drop", mmu_rst, 0);
    chk("R6 core stays after done drop", core_rst, 0);
  endtask

  task automatic t_core_hold();
    int n;
    power_down();
    wr_cnt(1'b0, 8'd1);
    wr_hold(3'b001);
    dom_on = 1'b1;
    init_done = 1'b1;
    wait_low(2, n);
    chk("R7 core held past done", core_rst, 1);
    init_done = 1'b0;
    cycles(5);
    chk("R7 core held after done drop", core_rst, 1);
    chk("R7 mmu released", mmu_rst, 0);
    wr_hold_measure(3'b100, 1, n);
    chk("R7 core after hold clear", n, 2);
  endtask

  task automatic t_seq();
    int n;
    power_down();
    wr_cnt(1'b0, 8'd1);
    wr_cnt(1'b1, 8'd5);
    wr_hold(3'b000);
    dom_on = 1'b1;
    init_done = 1'b1;
    wait_low(2, n);
    cycles(8);
    chk("R8 seq held by wake hold", seq_rst, 1);
    wr_hold_measure(3'b000, 3, n);
    chk("R8 seq latency", n, 5 + 2);
    chk("R10 seq flag", sts_q[1], 1);
  endtask

  task automatic t_w1c();
    chk("R11 both flags set", sts_q, 2'b11);
    clr_sts(2'b01);
    chk("R11 clear cold only", sts_q, 2'b10);
    clr_sts(2'b10);
    chk("R11 clear seq", sts_q, 2'b00);
  endtask

  task automatic t_powerdown();
    dom_on = 1'b0;
    #1;
    chk("R2 cold async", cold_rst, 1); chk("R2 core async", core_rst, 1);
    chk("R2 mmu async", mmu_rst, 1);   chk("R2 seq async", seq_rst, 1);
    @(negedge clk);
    chk("R2 clk_en off", dom_clk_en, 0);
    init_done = 1'b0;
    cycles(1);
    dom_on = 1'b1;
    cycles(1);
    chk("R2 rewake cold asserted", cold_rst, 1);
    chk("R2 rewake seq asserted", seq_rst, 1);
  endtask

  task automatic t_seq_stall();
    int n;
    power_down();
    wr_cnt(1'b0, 8'd6);
    wr_cnt(1'b1, 8'd3);
    dom_on = 1'b1;
    cycles(2);
    wr_hold(3'b000);
    cycles(14);
    chk("R9 cold released", cold_rst, 0);
    chk("R9 seq stalled by mmu", seq_rst, 1);
    init_done = 1'b1;
    wait_low(2, n);
    chk("R9 mmu on done", n, 1);
    wait_low(3, n);
    chk("R9 seq after mmu", n, 3 + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_cold_latency(3);
    t_cold_latency(0);
    t_mmu_hold_and_done();
    t_core_hold();
    t_seq();
    t_w1c();
    t_powerdown();
    t_seq_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule